// File: doc/BRIEF.md
# Real-Time Seconds Counter with Alarm Match

This block keeps elapsed time from a 32.768 kHz tick enable that is synchronous to the system clock. A 15-bit sub-seconds counter counts ticks and produces one carry per second. Each carry advances a 32-bit seconds counter, which wraps silently at its top. Software can preset the seconds value. Presetting it always restarts the sub-seconds count from zero. A trim value can shorten the sub-seconds period once every 64 seconds, which lets software correct for a fast or slow oscillator.

An alarm compares the running time with a seconds value and a sub-seconds value. The alarm fires when an update moves the counters onto exactly that pair. The alarm sets a sticky raw status bit, which is cleared by a write-one-to-clear pulse. A mask bit passes the raw status on to the interrupt output.

When calendar mode is selected, the counter path is locked out. Its outputs read as zero, loads are dropped and the count is frozen. Software reads the time coherently by reading seconds, then sub-seconds, then seconds again, and retrying if the two seconds readings differ.

Top module: `rtc_sec_counter`

## Requirements
- R1: After reset, `sec_o`, `sub_o`, `alm_raw` and `alm_irq` are all zero.
- R2: With `run_en`=1 and `cal_mode`=0, each clock with `tick_en`=1 changes the counters. If `sub_o` is below the terminal count, `sub_o` goes up by one. Otherwise `sub_o` returns to 0 and `sec_o` goes up by one. With `run_en`=0, ticks change nothing.
- R3: The terminal count is 0x7FFF. The one exception is when the low six bits of the current seconds value are zero. In that case the terminal count is `trim_cnt`, and any `trim_cnt` above 0x7FFF is treated as 0x7FFF.
- R4: When `load_stb`=1 and `cal_mode`=0, the next edge puts `load_sec` into the seconds counter and zero into the sub-seconds counter. This happens whatever the value of `run_en`, and the load wins over a tick in the same cycle.
- R5: The seconds counter goes from 0xFFFFFFFF to 0 with no flag.
- R6: While `cal_mode`=1, `sec_o` and `sub_o` read as zero, loads and ticks have no effect, and no alarm can fire. When `cal_mode` returns to 0, the values held before it was set reappear.
- R7: `alm_raw` is set on the edge where a tick or a load moves the counters onto values equal to both `match_sec` and `match_sub`. Equal seconds with unequal sub-seconds do not set it.
- R8: `alm_raw` stays set until a cycle with `alm_clr`=1. If a new match arrives in the same cycle as `alm_clr`, the bit stays set.
- R9: `alm_irq` is `alm_raw` AND `alm_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | 32.768 kHz tick, one clock wide |
| run_en | input | 1 | Counting enable |
| cal_mode | input | 1 | Calendar mode selected; locks out this path |
| load_stb | input | 1 | Seconds load strobe |
| load_sec | input | 32 | Seconds value to load |
| match_sec | input | 32 | Alarm seconds value |
| match_sub | input | 15 | Alarm sub-seconds value |
| alm_mask | input | 1 | Interrupt mask for the alarm |
| alm_clr | input | 1 | Write-one-to-clear pulse for the raw alarm |
| trim_cnt | input | 16 | Terminal count used in every 64th second |
| sec_o | output | 32 | Seconds value |
| sub_o | output | 15 | Sub-seconds value |
| alm_raw | output | 1 | Sticky raw alarm status |
| alm_irq | output | 1 | Masked alarm interrupt |

## Verification
A seconds load and a tick can land in the same clock. The bench provokes this by raising `load_stb` while `tick_en` is high. The result is judged correct only if the loaded seconds appear with a sub-seconds value of zero, with no extra count. An alarm clear and a fresh match can also coincide. The bench produces this by loading onto the match value in the same cycle as the clear pulse, and expects the raw status to remain set.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_W_D  = 32;
  localparam int SUB_W_D  = 15;
  localparam int TRIM_W_D = 16;
  localparam int GRP_W_D  = 6;

  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_TICK = 2'd1,
    UPD_WRAP = 2'd2,
    UPD_LOAD = 2'd3
  } upd_kind_t;
endpackage

// File: rtl/rtc_subsec_div.sv
module rtc_subsec_div
  import rtc_pkg::*;
#(
  parameter int SUB_W  = SUB_W_D,
  parameter int TRIM_W = TRIM_W_D,
  parameter int GRP_W  = GRP_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              clr,
  input  logic [GRP_W-1:0]  sec_grp,
  input  logic [TRIM_W-1:0] trim,
  output logic [SUB_W-1:0]  sub_q,
  output logic [SUB_W-1:0]  sub_nxt,
  output logic              carry,
  output upd_kind_t         kind
);
  localparam logic [SUB_W-1:0]  NOM   = {SUB_W{1'b1}};
  localparam logic [TRIM_W-1:0] NOM_T = TRIM_W'(NOM);

  function automatic logic [SUB_W-1:0] term_of(input logic [GRP_W-1:0] g,
                                               input logic [TRIM_W-1:0] t);
    if (g != '0) return NOM;
    if (t > NOM_T) return NOM;
    return t[SUB_W-1:0];
  endfunction

  logic [SUB_W-1:0] term;
  assign term  = term_of(sec_grp, trim);
  assign carry = step && !clr && (sub_q >= term);

  always_comb begin
    if (clr) begin
      sub_nxt = '0;
      kind    = UPD_LOAD;
    end else if (carry) begin
      sub_nxt = '0;
      kind    = UPD_WRAP;
    end else if (step) begin
      sub_nxt = sub_q + 1'b1;
      kind    = UPD_TICK;
    end else begin
      sub_nxt = sub_q;
      kind    = UPD_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sub_q <= '0;
    else        sub_q <= sub_nxt;

  a_r4_sub_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sub_q == '0));
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == UPD_WRAP) |=> (sub_q == '0));
  a_r2_sub_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(sub_q));
endmodule

// File: rtl/rtc_sec_reg.sv
module rtc_sec_reg #(
  parameter int SEC_W = rtc_pkg::SEC_W_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             carry,
  input  logic             ld,
  input  logic [SEC_W-1:0] ld_val,
  output logic [SEC_W-1:0] sec_q,
  output logic [SEC_W-1:0] sec_nxt
);
  function automatic logic [SEC_W-1:0] next_sec(input logic [SEC_W-1:0] cur,
                                                input logic c, input logic l,
                                                input logic [SEC_W-1:0] v);
    if (l) return v;
    if (c) return cur + 1'b1;
    return cur;
  endfunction

  assign sec_nxt = next_sec(sec_q, carry, ld, ld_val);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sec_q <= '0;
    else        sec_q <= sec_nxt;

  a_r4_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (sec_q == $past(ld_val)));
  a_r2_sec_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !carry) |=> $stable(sec_q));
  a_r5_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && carry && (sec_q == '1)) |=> (sec_q == '0));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int SEC_W = rtc_pkg::SEC_W_D,
  parameter int SUB_W = rtc_pkg::SUB_W_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [SEC_W-1:0] sec_nxt,
  input  logic [SUB_W-1:0] sub_nxt,
  input  logic [SEC_W-1:0] mt_sec,
  input  logic [SUB_W-1:0] mt_sub,
  input  logic             clr,
  input  logic             mask,
  output logic             hit,
  output logic             raw,
  output logic             irq
);
  function automatic logic is_match(input logic [SEC_W-1:0] s, input logic [SUB_W-1:0] ss,
                                    input logic [SEC_W-1:0] ms, input logic [SUB_W-1:0] mss);
    return (s == ms) && (ss == mss);
  endfunction

  assign hit = upd && is_match(sec_nxt, sub_nxt, mt_sec, mt_sub);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   raw <= 1'b0;
    else if (hit) raw <= 1'b1;
    else if (clr) raw <= 1'b0;

  assign irq = raw && mask;

  a_r7_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> raw);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !clr) |=> raw);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !raw);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw && !hit) |=> !raw);
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
  import rtc_pkg::*;
#(
  parameter int SEC_W  = SEC_W_D,
  parameter int SUB_W  = SUB_W_D,
  parameter int TRIM_W = TRIM_W_D,
  parameter int GRP_W  = GRP_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              run_en,
  input  logic              cal_mode,
  input  logic              load_stb,
  input  logic [SEC_W-1:0]  load_sec,
  input  logic [SEC_W-1:0]  match_sec,
  input  logic [SUB_W-1:0]  match_sub,
  input  logic              alm_mask,
  input  logic              alm_clr,
  input  logic [TRIM_W-1:0] trim_cnt,
  output logic [SEC_W-1:0]  sec_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic              alm_raw,
  output logic              alm_irq
);
  logic             step, ld_ok, carry, upd, hit;
  logic [SEC_W-1:0] sec_q, sec_nxt;
  logic [SUB_W-1:0] sub_q, sub_nxt;
  upd_kind_t        kind;

  assign step  = tick_en && run_en && !cal_mode;
  assign ld_ok = load_stb && !cal_mode;
  assign upd   = (kind != UPD_NONE);

  rtc_subsec_div #(.SUB_W(SUB_W), .TRIM_W(TRIM_W), .GRP_W(GRP_W)) u_sub (
    .clk(clk), .rst_n(rst_n), .step(step), .clr(ld_ok),
    .sec_grp(sec_q[GRP_W-1:0]), .trim(trim_cnt),
    .sub_q(sub_q), .sub_nxt(sub_nxt), .carry(carry), .kind(kind));

  rtc_sec_reg #(.SEC_W(SEC_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .carry(carry), .ld(ld_ok), .ld_val(load_sec),
    .sec_q(sec_q), .sec_nxt(sec_nxt));

  rtc_alarm #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_alm (
    .clk(clk), .rst_n(rst_n), .upd(upd), .sec_nxt(sec_nxt), .sub_nxt(sub_nxt),
    .mt_sec(match_sec), .mt_sub(match_sub), .clr(alm_clr), .mask(alm_mask),
    .hit(hit), .raw(alm_raw), .irq(alm_irq));

  assign sec_o = cal_mode ? '0 : sec_q;
  assign sub_o = cal_mode ? '0 : sub_q;

  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cal_mode |=> ($stable(sec_q) && $stable(sub_q)));
  a_r6_no_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    cal_mode |-> !hit);
  a_r4_load_beats_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ok && step) |=> (sub_q == '0 && sec_q == $past(load_sec)));
endmodule

// File: tb/test_rtc_sec_counter.sv
module test_rtc_sec_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 0, run_en = 0, cal_mode = 0, load_stb = 0;
  logic [31:0] load_sec = 0, match_sec = 32'hDEAD_0000;
  logic [14:0] match_sub = 15'h1234;
  logic        alm_mask = 0, alm_clr = 0;
  logic [15:0] trim_cnt = 16'h7FFF;
  logic [31:0] sec_o;
  logic [14:0] sub_o;
  logic        alm_raw, alm_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_sec_counter i_rtc_sec_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en), .cal_mode(cal_mode),
    .load_stb(load_stb), .load_sec(load_sec), .match_sec(match_sec), .match_sub(match_sub),
    .alm_mask(alm_mask), .alm_clr(alm_clr), .trim_cnt(trim_cnt),
    .sec_o(sec_o), .sub_o(sub_o), .alm_raw(alm_raw), .alm_irq(alm_irq));

  // row: load flag, load value, tick count, expected seconds, expected sub-seconds
  localparam logic [95:0] VEC [0:6] = '{
    {1'b1, 32'd0,          16'd3,     32'd0,          15'd3},
    {1'b0, 32'd0,          16'd1,     32'd1,          15'd0},
    {1'b1, 32'd63,         16'd32767, 32'd63,         15'h7FFF},
    {1'b0, 32'd0,          16'd1,     32'd64,         15'd0},
    {1'b0, 32'd0,          16'd4,     32'd65,         15'd0},
    {1'b1, 32'hFFFF_FFFF,  16'd32768, 32'd0,          15'd0},
    {1'b1, 32'h1234_5678,  16'd10,    32'h1234_5678,  15'd10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic load(input logic [31:0] v);
    load_stb = 1; load_sec = v;
    @(negedge clk);
    load_stb = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 sec", sec_o, 0);
    chk("R1 sub", 32'(sub_o), 0);
    chk("R1 raw", 32'(alm_raw), 0);
    chk("R1 irq", 32'(alm_irq), 0);
    rst_n = 1;
    @(negedge clk);

    // table walk: R2 counting, R3 trim, R5 wrap
    run_en = 1; trim_cnt = 16'd3;
    for (int i = 0; i < 7; i++) begin
      if (VEC[i][95]) load(VEC[i][94:63]);
      ticks(int'(VEC[i][62:47]));
      chk($sformatf("R2/R3/R5 row%0d sec", i), sec_o, VEC[i][46:15]);
      chk($sformatf("R2/R3/R5 row%0d sub", i), 32'(sub_o), 32'(VEC[i][14:0]));
    end

    // R3 trim above nominal is clamped
    trim_cnt = 16'hFFFF;
    load(32'd128);
    ticks(32767);
    chk("R3 clamp sub", 32'(sub_o), 32'h7FFF);
    ticks(1);
    chk("R3 clamp sec", sec_o, 129);
    trim_cnt = 16'h7FFF;

    // R2 no counting without run_en; R4 load still works
    run_en = 0;
    ticks(5);
    chk("R2 idle sub", 32'(sub_o), 0);
    load(32'd77);
    chk("R4 load idle", sec_o, 77);
    run_en = 1;

    // R4 load beats tick in the same cycle
    ticks(3);
    tick_en = 1; load(32'd100); tick_en = 0;
    chk("R4 collide sec", sec_o, 100);
    chk("R4 collide sub", 32'(sub_o), 0);

    // R6 calendar lockout
    cal_mode = 1;
    #1;
    chk("R6 sec zero", sec_o, 0);
    chk("R6 sub zero", 32'(sub_o), 0);
    @(negedge clk);
    tick_en = 1; load(32'd555); ticks(3);
    match_sec = 32'd100; match_sub = 15'd0;
    load(32'd100);
    chk("R6 no alarm", 32'(alm_raw), 0);
    cal_mode = 0;
    #1;
    chk("R6 sec kept", sec_o, 100);
    chk("R6 sub kept", 32'(sub_o), 0);
    @(negedge clk);

    // R7 match on both fields, R9 mask, R8 sticky/clear
    match_sec = 32'd200; match_sub = 15'd5;
    load(32'd200);
    chk("R7 sec only", 32'(alm_raw), 0);
    ticks(5);
    chk("R7 match", 32'(alm_raw), 1);
    chk("R9 masked", 32'(alm_irq), 0);
    alm_mask = 1; #1;
    chk("R9 unmasked", 32'(alm_irq), 1);
    @(negedge clk);
    ticks(4);
    chk("R8 sticky", 32'(alm_raw), 1);
    alm_clr = 1; @(negedge clk); alm_clr = 0;
    chk("R8 cleared", 32'(alm_raw), 0);
    chk("R9 irq low", 32'(alm_irq), 0);

    // R8 set wins over clear
    match_sec = 32'd300; match_sub = 15'd0;
    alm_clr = 1; load(32'd300); alm_clr = 0;
    chk("R8 set wins", 32'(alm_raw), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule